// File: doc/BRIEF.md
# Indirect Analog Control Register Port

This block exposes one 32-bit host-visible configuration word through which software reaches a hidden bank of 8-bit analog control registers. The word carries a bank reset control, a read/write strobe, a register address, a write-data byte and a read-data byte. To write, software raises the bank reset control, sets the address and data, and then raises the strobe bit. The write takes place on that rising step, and software then lowers the strobe again. To read, software leaves the strobe low, sets the address, and reads the low byte of the same word.

The bank has a depth of two to the power of the address width. By default that is 32 entries of 8 bits. Selected bits of three entries drive the analog enables and the ADC gain directly. The host bus is a plain single-cycle write port with a word that can always be read.

Top module: `ana_ctrl_port`

## Requirements
- R1: After reset the host word reads 0x0000_0000 and every exported enable and gain output is 0.
- R2: One clock after a host write, the host word returns the written bank reset control (bit 28), strobe (bit 24), address (bits 20:16) and write data (bits 15:8). Bits 31:29, 27:25 and 23:21 always read 0.
- R3: Bits 7:0 of the host word are read-only. A host write to them has no effect on the value read there.
- R4: A host write whose bit 24 is 1, whose bit 28 is 1, and that lands while the stored strobe is 0 writes bits 15:8 into the bank entry addressed by bits 20:16. The entry holds the new value one clock later.
- R5: A host write with bit 24 set while the stored strobe is already 1 writes nothing into the bank, even if its data or address differ.
- R6: A strobe rise written with bit 28 at 0 writes nothing into the bank.
- R7: While the stored bank reset control is 0, every bank entry is forced to 0x00. All exported outputs go to 0 within two clocks of the host write that clears bit 28.
- R8: Bits 7:0 return the bank entry selected by the stored address through one register stage. After a host write changes the address, the new entry appears one clock after the address itself does.
- R9: Exported bits are taken from fixed bank entries. Entry 0x07 bit 7 drives line-out enable. Entry 0x03 bits 7, 6, 5 and 4 drive DAC right, DAC left, mixer right and mixer left enables. Entry 0x0F bits 7 and 6 drive ADC right and left enables, and its bits 2:0 drive the ADC gain.
- R10: A write into the entry currently selected for reading appears in bits 7:0 one clock after the entry itself is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_we | input | 1 | Host write enable for the configuration word |
| csr_wdata | input | 32 | Host write data |
| csr_rdata | output | 32 | Live configuration word readback |
| line_out_en | output | 1 | Line-out enable |
| dac_r_en | output | 1 | DAC right channel enable |
| dac_l_en | output | 1 | DAC left channel enable |
| mix_r_en | output | 1 | Output mixer right enable |
| mix_l_en | output | 1 | Output mixer left enable |
| adc_r_en | output | 1 | ADC right channel enable |
| adc_l_en | output | 1 | ADC left channel enable |
| adc_gain | output | 3 | ADC gain code |

## Verification
Two things can meet in one clock edge. The bank clear driven by a low stored reset control can coincide with a strobe-rise commit that raises the reset control in the same host write. A commit into the entry being read can also coincide with the read-data register stage sampling that entry. The bench provokes both. It writes the reset control, the strobe and the data in a single word while the bank is held in reset, and it commits into the entry currently selected for reading. A cycle-by-cycle behavioural model decides the winner: the commit overrides the clear, and the read stage shows the old value for one clock before the new one.

// File: rtl/acp_pkg.sv
package acp_pkg;
  // Field positions of the host configuration word
  localparam int RST_POS  = 28;
  localparam int RW_POS   = 24;
  localparam int ADDR_LSB = 16;
  localparam int WDAT_LSB = 8;
  localparam int RDAT_LSB = 0;
  localparam int WORD_W   = 32;

  // Bank entries whose bits are exported
  localparam int ENT_LINEOUT = 7;
  localparam int ENT_PATH    = 3;
  localparam int ENT_ADC     = 15;

  localparam int GAIN_W = 3;
endpackage

// File: rtl/acp_rst_sync.sv
module acp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/acp_cfg_word.sv
module acp_cfg_word #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [31:0]       host_wdata,
  output logic              cfg_rst,
  output logic              cfg_rw,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_wdat,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  import acp_pkg::*;

  logic              rst_d, rw_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdat_d;
  logic              in_rst, in_rw;

  always_comb begin
    in_rst = host_wdata[RST_POS];
    in_rw  = host_wdata[RW_POS];
    rst_d  = cfg_rst;
    rw_d   = cfg_rw;
    addr_d = cfg_addr;
    wdat_d = cfg_wdat;
    if (host_we) begin
      rst_d  = in_rst;
      rw_d   = in_rw;
      addr_d = host_wdata[ADDR_LSB +: ADDR_W];
      wdat_d = host_wdata[WDAT_LSB +: DATA_W];
    end
    // Commit on the strobe's rising step, gated by the written reset control
    commit      = host_we && in_rw && !cfg_rw && in_rst;
    commit_addr = host_wdata[ADDR_LSB +: ADDR_W];
    commit_data = host_wdata[WDAT_LSB +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rst  <= 1'b0;
      cfg_rw   <= 1'b0;
      cfg_addr <= '0;
      cfg_wdat <= '0;
    end else begin
      cfg_rst  <= rst_d;
      cfg_rw   <= rw_d;
      cfg_addr <= addr_d;
      cfg_wdat <= wdat_d;
    end
  end
endmodule

// File: rtl/acp_bank.sv
module acp_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hold_clr,
  input  logic                    commit,
  input  logic [ADDR_W-1:0]       commit_addr,
  input  logic [DATA_W-1:0]       commit_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  output logic [DEPTH*DATA_W-1:0] bank_flat
);
  logic [DATA_W-1:0] rd_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q, ent_d;
    logic              ent_en;

    always_comb begin
      ent_en = 1'b0;
      ent_d  = ent_q;
      if (commit && (commit_addr == ADDR_W'(g))) begin
        ent_en = 1'b1;
        ent_d  = commit_data;
      end else if (hold_clr) begin
        ent_en = 1'b1;
        ent_d  = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign bank_flat[g*DATA_W +: DATA_W] = ent_q;
  end

  always_comb rd_d = bank_flat[rd_addr*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/ana_ctrl_port.sv
module ana_ctrl_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output logic        line_out_en,
  output logic        dac_r_en,
  output logic        dac_l_en,
  output logic        mix_r_en,
  output logic        mix_l_en,
  output logic        adc_r_en,
  output logic        adc_l_en,
  output logic [2:0]  adc_gain
);
  import acp_pkg::*;

  logic                    rst_sync_n;
  logic                    cfg_rst, cfg_rw, commit;
  logic [ADDR_W-1:0]       cfg_addr, commit_addr;
  logic [DATA_W-1:0]       cfg_wdat, commit_data, rd_data;
  logic [DEPTH*DATA_W-1:0] bank_flat;
  logic [DATA_W-1:0]       ent_lo, ent_path, ent_adc;

  acp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  acp_cfg_word #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .host_we(csr_we), .host_wdata(csr_wdata),
    .cfg_rst(cfg_rst), .cfg_rw(cfg_rw), .cfg_addr(cfg_addr), .cfg_wdat(cfg_wdat),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  acp_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .hold_clr(!cfg_rst), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data), .rd_addr(cfg_addr),
    .rd_data(rd_data), .bank_flat(bank_flat)
  );

  always_comb begin
    csr_rdata                           = '0;
    csr_rdata[RST_POS]                  = cfg_rst;
    csr_rdata[RW_POS]                   = cfg_rw;
    csr_rdata[ADDR_LSB +: ADDR_W]       = cfg_addr;
    csr_rdata[WDAT_LSB +: DATA_W]       = cfg_wdat;
    csr_rdata[RDAT_LSB +: DATA_W]       = rd_data;
  end

  always_comb begin
    ent_lo   = bank_flat[ENT_LINEOUT*DATA_W +: DATA_W];
    ent_path = bank_flat[ENT_PATH*DATA_W +: DATA_W];
    ent_adc  = bank_flat[ENT_ADC*DATA_W +: DATA_W];
    line_out_en = ent_lo[7];
    dac_r_en    = ent_path[7];
    dac_l_en    = ent_path[6];
    mix_r_en    = ent_path[5];
    mix_l_en    = ent_path[4];
    adc_r_en    = ent_adc[7];
    adc_l_en    = ent_adc[6];
    adc_gain    = ent_adc[GAIN_W-1:0];
  end
endmodule

// File: rtl/acp_checker.sv
module acp_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    csr_we,
  input logic [31:0]             csr_wdata,
  input logic [31:0]             csr_rdata,
  input logic                    line_out_en,
  input logic [2:0]              adc_gain,
  input logic [DEPTH*DATA_W-1:0] bank_flat
);
  logic              fire, hold_write;
  logic [DATA_W-1:0] sel_ent;
  logic [DATA_W-1:0] bank_w [DEPTH];

  always_comb begin
    fire = csr_we && csr_wdata[24] && csr_wdata[28] && !csr_rdata[24];
    hold_write = csr_we && csr_wdata[24] && csr_wdata[28] &&
                 csr_rdata[24] && csr_rdata[28];
    sel_ent = bank_flat[csr_rdata[20:16]*DATA_W +: DATA_W];
    for (int i = 0; i < DEPTH; i++) bank_w[i] = bank_flat[i*DATA_W +: DATA_W];
  end

  // R2 reserved bits and field readback
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:29] == 3'b0) && (csr_rdata[27:25] == 3'b0) && (csr_rdata[23:21] == 3'b0));

  a_r2_wdat_readback: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> csr_rdata[15:8] == $past(csr_wdata[15:8]));

  // R4 commit lands in the addressed entry
  a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> bank_w[$past(csr_wdata[20:16])] == $past(csr_wdata[15:8]));

  // R5 strobe held high writes nothing
  a_r5_no_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
    hold_write |=> $stable(bank_flat));

  // R7 bank held clear while reset control low
  a_r7_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rdata[28] && !fire) |=> (!line_out_en && adc_gain == 3'b0));

  // R8 read field one stage behind the selected entry
  a_r8_read_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> csr_rdata[7:0] == $past(sel_ent));
endmodule

bind ana_ctrl_port acp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .line_out_en(line_out_en), .adc_gain(adc_gain),
  .bank_flat(bank_flat)
);

// File: tb/sim_ana_ctrl_port.sv
`timescale 1ns/1ps
module sim_ana_ctrl_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        line_out_en, dac_r_en, dac_l_en, mix_r_en, mix_l_en;
  logic        adc_r_en, adc_l_en;
  logic [2:0]  adc_gain;

  int checks = 0, failures = 0;
  string phase = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  ana_ctrl_port u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .line_out_en(line_out_en), .dac_r_en(dac_r_en),
    .dac_l_en(dac_l_en), .mix_r_en(mix_r_en), .mix_l_en(mix_l_en),
    .adc_r_en(adc_r_en), .adc_l_en(adc_l_en), .adc_gain(adc_gain)
  );

  // Behavioural reference model
  int m_bank [32];
  int m_rst, m_rw, m_addr, m_wdat, m_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_bank[i] = 0;
      m_rst = 0; m_rw = 0; m_addr = 0; m_wdat = 0; m_rd = 0;
    end else begin
      int nxt_rd;
      bit fire;
      nxt_rd = m_bank[m_addr];
      fire = csr_we && csr_wdata[24] && csr_wdata[28] && (m_rw == 0);
      if (fire) m_bank[csr_wdata[20:16]] = csr_wdata[15:8];
      else if (m_rst == 0) for (int i = 0; i < 32; i++) m_bank[i] = 0;
      if (csr_we) begin
        m_rst = csr_wdata[28]; m_rw = csr_wdata[24];
        m_addr = csr_wdata[20:16]; m_wdat = csr_wdata[15:8];
      end
      m_rd = nxt_rd;
    end
  end

  function automatic logic [31:0] model_word();
    return {3'b0, 1'(m_rst), 3'b0, 1'(m_rw), 3'b0, 5'(m_addr), 8'(m_wdat), 8'(m_rd)};
  endfunction

  function automatic logic [9:0] model_outs();
    logic [7:0] p, a, l;
    p = 8'(m_bank[3]); a = 8'(m_bank[15]); l = 8'(m_bank[7]);
    return {l[7], p[7], p[6], p[5], p[4], a[7], a[6], a[2:0]};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(phase, csr_rdata, model_word());
      chk(phase, {line_out_en, dac_r_en, dac_l_en, mix_r_en, mix_l_en,
                  adc_r_en, adc_l_en, adc_gain}, 32'(model_outs()));
    end
  end

  task automatic host_wr(logic [31:0] v);
    @(negedge clk); csr_we = 1'b1; csr_wdata = v;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] w(bit r, bit s, int a, int d, int lo = 0);
    return (32'(r) << 28) | (32'(s) << 24) | (32'(a) << 16) | (32'(d) << 8) | 32'(lo);
  endfunction

  task automatic commit_seq(int a, int d);
    host_wr(w(1, 0, a, d));
    host_wr(w(1, 1, a, d));
    host_wr(w(1, 0, a, d));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);
    chk("R1", csr_rdata, 32'h0);
    chk("R1", {29'b0, line_out_en, adc_r_en, adc_gain[0]}, 32'h0);

    phase = "R2";
    host_wr(32'hFFFF_FF00 & w(1, 0, 5'h1F, 8'hA5));
    chk("R2", csr_rdata, 32'h101F_A500);
    host_wr(32'hEEEE_EEEE & ~32'h0100_0000);
    chk("R2 reserved", csr_rdata & 32'hEEE0_0000, 32'h0);

    phase = "R4";
    commit_seq(7, 8'h80);
    chk("R4/R9 line-out", 32'(line_out_en), 32'd1);
    commit_seq(3, 8'hA0);
    chk("R9 dac_r", 32'(dac_r_en), 32'd1);
    chk("R9 dac_l", 32'(dac_l_en), 32'd0);
    chk("R9 mix_r", 32'(mix_r_en), 32'd1);
    chk("R9 mix_l", 32'(mix_l_en), 32'd0);

    phase = "R8";
    host_wr(w(1, 0, 3, 0));
    idle(1);
    chk("R8 read field", 32'(csr_rdata[7:0]), 32'hA0);

    phase = "R5";
    host_wr(w(1, 0, 15, 8'hC5));
    host_wr(w(1, 1, 15, 8'hC5));
    host_wr(w(1, 1, 15, 8'h02));
    host_wr(w(1, 1, 7, 8'h00));
    chk("R5 gain", 32'(adc_gain), 32'd5);
    chk("R5 adc en", 32'({adc_r_en, adc_l_en}), 32'd3);
    chk("R5 line-out", 32'(line_out_en), 32'd1);
    host_wr(w(1, 0, 15, 0));

    phase = "R3";
    host_wr(w(1, 0, 5'h1E, 0, 8'hFF));
    idle(1);
    chk("R3 read-only", 32'(csr_rdata[7:0]), 32'h00);

    phase = "R10";
    host_wr(w(1, 1, 5'h1E, 8'h5A));
    chk("R10 old value", 32'(csr_rdata[7:0]), 32'h00);
    idle(1);
    chk("R10 new value", 32'(csr_rdata[7:0]), 32'h5A);
    host_wr(w(1, 0, 5'h1E, 8'h5A));

    phase = "R7";
    host_wr(w(0, 0, 0, 0));
    idle(1);
    chk("R7 cleared", 32'({line_out_en, dac_r_en, mix_r_en, adc_r_en, adc_l_en, adc_gain}), 32'h0);

    phase = "R6";
    host_wr(w(0, 1, 7, 8'h80));
    idle(1);
    chk("R6 ignored", 32'(line_out_en), 32'd0);
    host_wr(w(0, 0, 7, 8'h80));

    phase = "R4 commit over clear";
    host_wr(w(1, 1, 15, 8'h07));
    chk("R4 commit wins", 32'(adc_gain), 32'd7);
    host_wr(w(1, 0, 15, 0));
    idle(2);
    chk("R4 entry held", 32'(csr_rdata[7:0]), 32'h07);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule